// File: doc/BRIEF.md
# Routed Interrupt Source Controller

The block collects seven level-sensitive interrupt inputs from on-chip agents and steers each one onto one of eight output interrupt lines. Routing is held in six vector registers. Each register carries a 16-bit server tag, an 8-bit priority, a 3-bit line selector and a pending flag. Two of the inputs, the link input and the service-processor input, share vector 0. Each of the remaining five inputs has its own vector register.

The block tracks a status bit per input and raises or lowers output lines when inputs change. It also keeps each pending flag equal to "asserted and not masked". A priority of all ones masks a source. The mask only affects the pending flag: an output line still follows its source. Software reaches the vectors and the two status words through a simple single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, vector i (i = 0..5) reads server 0, priority 0xFF, selector i and pending 0. All output lines are low and both status words read 0.
- R2: A vector word places the server in bits 55..40, the priority in 39..32, the selector in 31..29 and pending in bit 24. Addresses 0..5 select vectors 0..5. A write changes only server, priority and selector; all other written bits, including bit 24, are ignored and the stored pending flag is kept.
- R3: A vector write with priority 0xFF clears that vector's pending flag in the same update.
- R4: A vector write whose selector is 6 or 7 (not below the vector count) leaves the whole vector unchanged.
- R5: Input order is irq_i[0] link, irq_i[1] service processor, irq_i[2..6] feeding vectors 1..5. Address 8 shows irq_i[0] at bit 47 and irq_i[1] at bit 46. Address 9 shows irq_i[2] at bit 36 down to irq_i[6] at bit 32. Each status bit equals its input as sampled at the previous clock edge.
- R6: A rising input raises the output line named by its vector's selector one clock later, whether or not the vector is masked.
- R7: A falling input on a non-shared source lowers its vector's selected line one clock later.
- R8: For the shared pair, the line of vector 0 is lowered only when both shared inputs are low. Lowering one while the other stays high leaves the line and pending flag asserted.
- R9: Whenever an input of a vector changes, that vector's pending flag becomes (OR of its new input levels) AND (priority not 0xFF).
- R10: Addresses 8 and 9 are read-only, and writes there have no effect. Any address other than 0..5, 8 and 9 reads all ones and ignores writes.
- R11: When a vector write and an input change on that vector fall in the same cycle, the newly written selector and priority govern the line choice and the pending flag.
- R12: When one line is raised by one vector and lowered by another in the same cycle, it ends up raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 7 | Level interrupt inputs (0 link, 1 service processor, 2..6 single sources) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| lines_o | output | 8 | Routed output interrupt lines |

## Verification
Two collisions can fall in the same cycle. The first is a software rewrite of a vector together with an edge on one of its inputs. The bench provokes it by pairing a selector-and-priority write with the rising edge of that vector's input. It then judges that the line chosen and the pending flag follow the new fields. The second is one vector raising a line while another vector lowers the same line. Two vectors are pointed at one selector, one input falls as the other rises, and the line must stay high. A behavioural reference model is compared against the lines and the read data on every clock, including a random run that mixes both collisions.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W        = 64;
  localparam int SRV_LSB       = 40;
  localparam int SRV_W         = 16;
  localparam int PRI_LSB       = 32;
  localparam int PRI_W         = 8;
  localparam int SEL_LSB       = 29;
  localparam int SEL_W         = 3;
  localparam int PEND_BIT      = 24;
  localparam int LINK_STAT_BIT = 47;
  localparam int SVC_STAT_BIT  = 46;
  localparam int SRC_STAT_MSB  = 36;
  localparam int ADDR_STAT_SHR = 8;
  localparam int ADDR_STAT_SRC = 9;

  typedef struct packed {
    logic [SRV_W-1:0] server;
    logic [PRI_W-1:0] prio;
    logic [SEL_W-1:0] sel;
    logic             pend;
  } vec_t;

  function automatic logic [DATA_W-1:0] vec_to_word(vec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SRV_LSB +: SRV_W] = v.server;
    w[PRI_LSB +: PRI_W] = v.prio;
    w[SEL_LSB +: SEL_W] = v.sel;
    w[PEND_BIT]         = v.pend;
    return w;
  endfunction
endpackage

// File: rtl/irq_route_status.sv
module irq_route_status #(
  parameter int NUM_IN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  output logic [NUM_IN-1:0] stat_o,
  output logic [NUM_IN-1:0] rise_o,
  output logic [NUM_IN-1:0] fall_o
);
  logic [NUM_IN-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= irq_i;
  end

  assign stat_o = stat_q;
  assign rise_o = irq_i & ~stat_q;
  assign fall_o = ~irq_i & stat_q;
endmodule

// File: rtl/irq_route_vec_slot.sv
module irq_route_vec_slot
  import irq_route_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_VEC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chg_i,
  input  logic              level_i,
  output vec_t              vec_o,
  output logic [SEL_W-1:0]  sel_eff_o
);
  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(NUM_VEC);
  localparam vec_t RST_VAL = '{server: '0, prio: '1, sel: SEL_W'(IDX), pend: 1'b0};

  vec_t             q, d;
  logic [SEL_W-1:0] w_sel;
  logic             wr_ok;
  logic             masked_nxt;

  assign w_sel = wdata_i[SEL_LSB +: SEL_W];
  assign wr_ok = wr_i && ({1'b0, w_sel} < SEL_LIMIT);

  always_comb begin
    d = q;
    if (wr_ok) begin
      d.server = wdata_i[SRV_LSB +: SRV_W];
      d.prio   = wdata_i[PRI_LSB +: PRI_W];
      d.sel    = w_sel;
    end
    masked_nxt = &d.prio;
    // input events are judged against the fields written in the same cycle
    if (chg_i) d.pend = level_i & ~masked_nxt;
    else       d.pend = q.pend & ~masked_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d;
  end

  assign vec_o     = q;
  assign sel_eff_o = d.sel;
endmodule

// File: rtl/irq_route_lines.sv
module irq_route_lines
  import irq_route_pkg::*;
#(
  parameter int NUM_VEC   = 6,
  parameter int NUM_LINES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_VEC-1:0]             set_i,
  input  logic [NUM_VEC-1:0]             clr_i,
  input  logic [NUM_VEC-1:0][SEL_W-1:0]  sel_i,
  output logic [NUM_LINES-1:0]           lines_o
);
  logic [NUM_LINES-1:0] lines_q;
  logic [NUM_LINES-1:0] set_m, clr_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (sel_i[v] == SEL_W'(l)) begin
          set_m[l] = set_m[l] | set_i[v];
          clr_m[l] = clr_m[l] | clr_i[v];
        end
      end
    end
  end

  // raise beats lower on a shared line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lines_q <= '0;
    else         lines_q <= (lines_q & ~clr_m) | set_m;
  end

  assign lines_o = lines_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_VEC = 6,
  parameter int ADDR_W  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_VEC:0]       irq_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic [(1<<SEL_W)-1:0]  lines_o
);
  localparam int NUM_IN    = NUM_VEC + 1;
  localparam int NUM_LINES = 1 << SEL_W;

  logic [NUM_IN-1:0]              stat, rise, fall;
  logic [NUM_VEC-1:0]             chg, lvl, set_ev, clr_ev, wr_hit;
  logic [NUM_VEC-1:0][SEL_W-1:0]  sel_eff;
  logic [NUM_VEC-1:0][SEL_W-1:0]  vec_sel;
  logic [NUM_VEC-1:0][PRI_W-1:0]  vec_prio;
  logic [NUM_VEC-1:0]             vec_pend;
  vec_t                           vecs [NUM_VEC];

  irq_route_status #(.NUM_IN(NUM_IN)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .stat_o (stat),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v == 0) begin : g_shared
      assign chg[v]    = |(rise[1:0] | fall[1:0]);
      assign lvl[v]    = |irq_i[1:0];
      assign set_ev[v] = |rise[1:0];
    end else begin : g_single
      assign chg[v]    = rise[v+1] | fall[v+1];
      assign lvl[v]    = irq_i[v+1];
      assign set_ev[v] = rise[v+1];
    end
    assign clr_ev[v] = chg[v] & ~lvl[v];
    assign wr_hit[v] = reg_we_i && (reg_addr_i == ADDR_W'(v));

    irq_route_vec_slot #(.IDX(v), .NUM_VEC(NUM_VEC)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_hit[v]),
      .wdata_i   (reg_wdata_i),
      .chg_i     (chg[v]),
      .level_i   (lvl[v]),
      .vec_o     (vecs[v]),
      .sel_eff_o (sel_eff[v])
    );

    assign vec_sel[v]  = vecs[v].sel;
    assign vec_prio[v] = vecs[v].prio;
    assign vec_pend[v] = vecs[v].pend;
  end

  irq_route_lines #(.NUM_VEC(NUM_VEC), .NUM_LINES(NUM_LINES)) u_lines (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_ev),
    .clr_i   (clr_ev),
    .sel_i   (sel_eff),
    .lines_o (lines_o)
  );

  always_comb begin
    reg_rdata_o = '1;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (reg_addr_i == ADDR_W'(v)) reg_rdata_o = vec_to_word(vecs[v]);
    end
    if (reg_addr_i == ADDR_W'(ADDR_STAT_SHR)) begin
      reg_rdata_o = '0;
      reg_rdata_o[LINK_STAT_BIT] = stat[0];
      reg_rdata_o[SVC_STAT_BIT]  = stat[1];
    end
    if (reg_addr_i == ADDR_W'(ADDR_STAT_SRC)) begin
      reg_rdata_o = '0;
      for (int k = 1; k < NUM_VEC; k++) reg_rdata_o[SRC_STAT_MSB-k+1] = stat[k+1];
    end
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_VEC = 6,
  parameter int ADDR_W  = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_VEC:0]              irq_i,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [DATA_W-1:0]             reg_rdata_o,
  input logic [(1<<SEL_W)-1:0]         lines_o,
  input logic [NUM_VEC:0]              stat_i,
  input logic [NUM_VEC-1:0][SEL_W-1:0] vec_sel_i,
  input logic [NUM_VEC-1:0][PRI_W-1:0] vec_prio_i,
  input logic [NUM_VEC-1:0]            vec_pend_i
);
  logic past_ok;
  logic unmapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign unmapped = (reg_addr_i >= ADDR_W'(NUM_VEC)) &&
                    (reg_addr_i != ADDR_W'(ADDR_STAT_SHR)) &&
                    (reg_addr_i != ADDR_W'(ADDR_STAT_SRC));

  AST_STATUS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (stat_i == $past(irq_i)));  // R5

  AST_UNMAPPED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (reg_rdata_o == '1));  // R10

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vchk
    AST_MASK_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&vec_prio_i[v]) |-> !vec_pend_i[v]);  // R3

    AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_sel_i[v] < SEL_W'(NUM_VEC));  // R4
  end

  for (genvar k = 2; k <= NUM_VEC; k++) begin : g_rchk
    AST_LINE_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_we_i && irq_i[k] && !stat_i[k]) |=> lines_o[$past(vec_sel_i[k-1])]);  // R6
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .lines_o     (lines_o),
  .stat_i      (stat),
  .vec_sel_i   (vec_sel),
  .vec_prio_i  (vec_prio),
  .vec_pend_i  (vec_pend)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [7:0]  lines;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference model state
  int        m_srv [6];
  int        m_pri [6];
  int        m_sel [6];
  bit        m_pend [6];
  bit [6:0]  m_stat;
  bit [7:0]  m_lines;

  always #5 clk = ~clk;

  irq_route_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_i       (irq),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .lines_o     (lines)
  );

  function automatic int vec_of(int i);
    return (i < 2) ? 0 : i - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 6; v++) begin
        m_srv[v] = 0; m_pri[v] = 255; m_sel[v] = v; m_pend[v] = 0;
      end
      m_stat = '0;
      m_lines = '0;
    end else begin
      bit [7:0] set_m, clr_m;
      bit rise_v [6];
      bit chg_v [6];
      bit lvl_v [6];
      int s;
      if (we && addr < 6) begin
        s = int'((wdata >> 29) & 64'h7);
        if (s < 6) begin
          m_srv[addr] = int'((wdata >> 40) & 64'hFFFF);
          m_pri[addr] = int'((wdata >> 32) & 64'hFF);
          m_sel[addr] = s;
          if (m_pri[addr] == 255) m_pend[addr] = 0;
        end
      end
      for (int v = 0; v < 6; v++) begin
        rise_v[v] = 0; chg_v[v] = 0; lvl_v[v] = 0;
      end
      for (int i = 0; i < 7; i++) begin
        if (irq[i] && !m_stat[i]) rise_v[vec_of(i)] = 1;
        if (irq[i] != m_stat[i])  chg_v[vec_of(i)] = 1;
        if (irq[i])               lvl_v[vec_of(i)] = 1;
      end
      set_m = '0; clr_m = '0;
      for (int v = 0; v < 6; v++) begin
        if (chg_v[v]) begin
          m_pend[v] = lvl_v[v] && (m_pri[v] != 255);
          if (rise_v[v])    set_m[m_sel[v]] = 1'b1;
          else if (!lvl_v[v]) clr_m[m_sel[v]] = 1'b1;
        end
      end
      m_lines = (m_lines & ~clr_m) | set_m;
      m_stat = irq;
    end
  end

  function automatic logic [63:0] exp_read(logic [3:0] a);
    logic [63:0] r;
    r = '1;
    if (a < 6) begin
      r = '0;
      r[55:40] = 16'(m_srv[a]);
      r[39:32] = 8'(m_pri[a]);
      r[31:29] = 3'(m_sel[a]);
      r[24]    = m_pend[a];
    end else if (a == 8) begin
      r = '0; r[47] = m_stat[0]; r[46] = m_stat[1];
    end else if (a == 9) begin
      r = '0;
      for (int k = 2; k < 7; k++) r[38-k] = m_stat[k];
    end
    return r;
  endfunction

  task automatic check(string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("lines", {56'd0, lines}, {56'd0, m_lines});
    check("rdata", rdata, exp_read(addr));
  endtask

  function automatic logic [63:0] mkvec(int srv, int pri, int sel);
    logic [63:0] w;
    w = 64'hFF00_0000_1FFF_FFFF;  // junk outside the writable fields
    w[55:40] = 16'(srv);
    w[39:32] = 8'(pri);
    w[31:29] = 3'(sel);
    return w;
  endfunction

  task automatic wr(int a, logic [63:0] d);
    we = 1'b1; addr = 4'(a); wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(int a);
    addr = 4'(a);
    step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R10 unmapped read
    tag = "R1";
    for (int a = 0; a < 6; a++) rd(a);
    rd(8); rd(9);
    tag = "R10";
    rd(12); rd(7);

    // R2 field placement, junk ignored
    tag = "R2";
    wr(2, mkvec(16'hABCD, 5, 4));
    rd(2);

    // R6 raise on vector 2 and on masked vector 1, R9 pending
    tag = "R6";
    irq[3] = 1'b1; step();
    irq[2] = 1'b1; step();
    tag = "R5";
    rd(9); rd(8);
    tag = "R9";
    rd(2); rd(1);

    // R2 pending kept across rewrite
    tag = "R2";
    wr(2, mkvec(16'h1234, 6, 4));
    rd(2);

    // R3 masking write clears pending
    tag = "R3";
    wr(2, mkvec(16'h1234, 255, 4));
    rd(2);

    // R7 fall lowers line
    tag = "R7";
    irq[3] = 1'b0; step();
    irq[2] = 1'b0; step();

    // R4 illegal selector rejected
    tag = "R4";
    wr(3, mkvec(16'h7777, 3, 7));
    rd(3);
    wr(3, mkvec(16'h7777, 3, 6));
    rd(3);

    // R8 shared pair
    tag = "R8";
    wr(0, mkvec(16'h0042, 1, 0));
    irq[0] = 1'b1; step();
    irq[1] = 1'b1; step();
    irq[0] = 1'b0; step();
    rd(0); rd(8);
    irq[1] = 1'b0; step();
    rd(0);

    // R10 status words and unmapped space ignore writes
    tag = "R10";
    irq[4] = 1'b1; irq[1] = 1'b1; step();
    wr(9, '0); rd(9);
    wr(8, '0); rd(8);
    wr(13, '0); rd(13);
    irq[4] = 1'b0; irq[1] = 1'b0; step();

    // R11 write and input edge in one cycle
    tag = "R11";
    irq[5] = 1'b1;
    wr(4, mkvec(16'h0001, 2, 5));
    rd(4);
    irq[5] = 1'b0; step();

    // R12 raise and lower of one line in one cycle
    tag = "R12";
    wr(3, mkvec(0, 9, 2));
    wr(5, mkvec(0, 9, 2));
    irq[4] = 1'b1; step();
    irq[4] = 1'b0; irq[6] = 1'b1; step();
    step();
    irq[6] = 1'b0; step();

    // R9 random mix
    tag = "R9";
    for (int c = 0; c < 600; c++) begin
      if ($urandom_range(0, 3) == 0) irq[$urandom_range(0, 6)] ^= 1'b1;
      if ($urandom_range(0, 5) == 0) begin
        we = 1'b1;
        addr = 4'($urandom_range(0, 9));
        wdata = mkvec($urandom_range(0, 65535),
                      ($urandom_range(0, 2) == 0) ? 255 : $urandom_range(0, 254),
                      $urandom_range(0, 7));
      end else begin
        we = 1'b0;
        addr = 4'($urandom_range(0, 15));
      end
      step();
    end
    we = 1'b0;
    finish_run();
  end
endmodule